// File: doc/BRIEF.md
# Character Cell Pixel Generator

This block produces the dot pattern for a single-row, sixteen-cell character display. For each scan step it takes a display cell index and a dot-row index. It converts the cell into an address in display-data storage, fetches the stored character code, and looks up a five-dot row. The dot row comes from a writable glyph store for user-defined characters, or from a fixed font stub for all other codes. The display, cursor and blink controls then act on that row, and the result is registered on the output one clock later.

The cell-to-address mapping is split. The left half of the row reads one bank of display storage and the right half reads a second bank that starts at address 40h. Each half has its own wrap-around window of LINE_LEN entries. A window offset input shifts the visible part of both halves at once and does not disturb the address counter. A simple write port on each store lets the surrounding controller load character codes and glyph rows.

Top module: `lcd_cellpix`

## Requirements
- R1: With a window offset of 0, cells 0..7 (display positions 1..8) read display addresses 00h..07h and cells 8..15 read addresses 40h..47h. The address is {bank, 6-bit index}, where bank is 1 for cells 8..15.
- R2: The 6-bit index is ((cell mod 8) + shift_ofs) mod LINE_LEN, with LINE_LEN = 40. Display writes with an index of LINE_LEN or more are dropped, and the address counter input takes no part in forming the read address.
- R3: A code whose bits 7..4 are all zero selects the glyph store at address {code[2:0], row[2:0]}. Code bit 3 is ignored, so codes 00h and 08h show the same glyph.
- R4: The output takes glyph bits 4..0, with pix[4] as the leftmost dot and 1 meaning lit. Glyph bits 7..5 are stored but never reach the output.
- R5: Every code with a nonzero upper nibble gives the font stub row code[4:0] XOR {2'b00, row}.
- R6: When cursor_on=1, the row is 7 and the cell's display address equals addr_cnt, all five dots are lit, because the cursor is ORed onto the glyph row.
- R7: When blink_on=1 and the cell's address equals addr_cnt, every row of that cell shows 11111b while the blink phase is on, and shows its normal content otherwise. The phase starts off at reset and toggles every BLINK_TICKS clocks.
- R8: When disp_on=0 the output is 00000b. The stored contents are kept, so the image returns on the first row after disp_on goes back to 1.
- R9: The output is registered. The inputs present at one rising edge determine pix after that edge, and pix is 00000b while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_pos | input | 4 | Display cell index, 0..15 |
| scan_row | input | 3 | Dot row within the cell, 0..7 |
| addr_cnt | input | 7 | Address counter (cursor location) |
| disp_on | input | 1 | Display enable |
| cursor_on | input | 1 | Cursor underline enable |
| blink_on | input | 1 | Cursor cell blink enable |
| shift_ofs | input | 6 | Visible window offset |
| dd_we | input | 1 | Display storage write enable |
| dd_waddr | input | 7 | Display storage write address |
| dd_wdata | input | 8 | Character code to write |
| cg_we | input | 1 | Glyph store write enable |
| cg_waddr | input | 6 | Glyph store write address {glyph, row} |
| cg_wdata | input | 8 | Glyph row data |
| pix | output | 5 | Dot row, bit 4 leftmost |

## Verification
Some properties are checked on every cycle: a disabled display gives a dark row, the cursor row and the blink-on cell give an all-lit row, the blink counter stays in range and the phase changes only when the counter wraps, and every display read index stays inside its window. The remaining behaviour is shown only by the bench's scenarios, comparing against mirrored storage. This covers the split address map, the offset window wrap, the glyph store selection with bit 3 ignored, the masking of the upper glyph bits, the font stub rows and the restoration of the image after the display is re-enabled.

// File: rtl/lcdpix_pkg.sv
package lcdpix_pkg;
  localparam int DOT_W  = 5;
  localparam int CODE_W = 8;
  localparam int ROW_W  = 3;

  typedef logic [DOT_W-1:0]  dots_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [ROW_W-1:0]  row_t;

  function automatic dots_t font_stub(input code_t c, input row_t r);
    return c[DOT_W-1:0] ^ {{(DOT_W-ROW_W){1'b0}}, r};
  endfunction

  function automatic logic code_is_user(input code_t c);
    return c[CODE_W-1:4] == '0;
  endfunction
endpackage

// File: rtl/lcdpix_dd_store.sv
module lcdpix_dd_store #(
  parameter int LINE_LEN = 40,
  parameter int AW       = 7
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int IW = AW - 1;
  localparam logic [IW-1:0] LEN_V = IW'(LINE_LEN);

  logic [7:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [LINE_LEN];
    logic       wr_hit;
    assign wr_hit = we && (waddr[AW-1] == 1'(b)) && (waddr[IW-1:0] < LEN_V);
    always_ff @(posedge clk) begin
      if (wr_hit) mem[waddr[IW-1:0]] <= wdata;
    end
    assign bank_rd[b] = mem[raddr[IW-1:0]];
  end

  assign rdata = bank_rd[raddr[AW-1]];

  AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_q)
    raddr[IW-1:0] < LEN_V); // R2
endmodule

// File: rtl/lcdpix_cg_store.sv
module lcdpix_cg_store #(
  parameter int GLYPHS = 8,
  parameter int ROWS   = 8,
  localparam int AW    = $clog2(GLYPHS * ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [GLYPHS * ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lcdpix_blink_timer.sv
module lcdpix_blink_timer #(
  parameter int TICKS = 108000,
  localparam int CW   = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst_q,
  output logic phase
);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q <= LAST); // R7
  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(cnt_q) != LAST) |-> $stable(phase_q)); // R7
endmodule

// File: rtl/lcd_cellpix.sv
module lcd_cellpix
  import lcdpix_pkg::*;
#(
  parameter int CELLS       = 16,
  parameter int LINE_LEN    = 40,
  parameter int BLINK_TICKS = 108000,
  localparam int POS_W = $clog2(CELLS),
  localparam int HALF  = CELLS / 2,
  localparam int HW    = $clog2(HALF),
  localparam int SH_W  = $clog2(LINE_LEN),
  localparam int AW    = SH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] scan_pos,
  input  logic [2:0]       scan_row,
  input  logic [AW-1:0]    addr_cnt,
  input  logic             disp_on,
  input  logic             cursor_on,
  input  logic             blink_on,
  input  logic [SH_W-1:0]  shift_ofs,
  input  logic             dd_we,
  input  logic [AW-1:0]    dd_waddr,
  input  logic [7:0]       dd_wdata,
  input  logic             cg_we,
  input  logic [5:0]       cg_waddr,
  input  logic [7:0]       cg_wdata,
  output logic [4:0]       pix
);
  localparam logic [SH_W:0] LEN_V = (SH_W+1)'(LINE_LEN);

  // reset: asserted asynchronously, released on the clock
  logic rs_a, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs_a  <= 1'b1;
      rst_q <= rs_a;
    end
  end

  // cell to display address
  logic [SH_W:0]   win_sum, win_idx;
  logic [AW-1:0]   rd_addr;
  logic            cell_hit;
  always_comb begin
    win_sum  = (SH_W+1)'(scan_pos[HW-1:0]) + (SH_W+1)'(shift_ofs);
    win_idx  = (win_sum >= LEN_V) ? win_sum - LEN_V : win_sum;
    rd_addr  = {scan_pos[POS_W-1], win_idx[SH_W-1:0]};
    cell_hit = (rd_addr == addr_cnt);
  end

  code_t     code;
  logic [7:0] cg_row;
  logic       blink_phase;

  lcdpix_dd_store #(.LINE_LEN(LINE_LEN), .AW(AW)) u_dd (
    .clk(clk), .rst_q(rst_q), .we(dd_we), .waddr(dd_waddr), .wdata(dd_wdata),
    .raddr(rd_addr), .rdata(code)
  );

  lcdpix_cg_store #(.GLYPHS(8), .ROWS(8)) u_cg (
    .clk(clk), .we(cg_we), .waddr(cg_waddr), .wdata(cg_wdata),
    .raddr({code[2:0], scan_row}), .rdata(cg_row)
  );

  lcdpix_blink_timer #(.TICKS(BLINK_TICKS)) u_blink (
    .clk(clk), .rst_q(rst_q), .phase(blink_phase)
  );

  // dot row selection and attribute overlay
  dots_t glyph, pix_d, pix_q;
  logic  under_row;
  always_comb begin
    glyph     = code_is_user(code) ? cg_row[4:0] : font_stub(code, scan_row);
    under_row = cursor_on && cell_hit && (scan_row == 3'd7);
    if (!disp_on)
      pix_d = '0;
    else if (blink_on && cell_hit && blink_phase)
      pix_d = '1;
    else
      pix_d = glyph | {DOT_W{under_row}};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  assign pix = pix_q;

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(!disp_on)) |-> (pix == 5'h00)); // R8
  AST_CURSOR_ROW_LIT: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(disp_on && cursor_on && cell_hit && scan_row == 3'd7))
      |-> (pix == 5'h1f)); // R6
  AST_BLINK_CELL_LIT: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(disp_on && blink_on && cell_hit && blink_phase))
      |-> (pix == 5'h1f)); // R7
endmodule

// File: tb/lcd_cellpix_tb.sv
module lcd_cellpix_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 6;

  logic       clk, rst_n;
  logic [3:0] scan_pos;
  logic [2:0] scan_row;
  logic [6:0] addr_cnt;
  logic       disp_on, cursor_on, blink_on;
  logic [5:0] shift_ofs;
  logic       dd_we, cg_we;
  logic [6:0] dd_waddr;
  logic [5:0] cg_waddr;
  logic [7:0] dd_wdata, cg_wdata;
  logic [4:0] pix;

  int total, bad, edges;
  bit done;
  logic [7:0] dd_m [128];
  logic [7:0] cg_m [64];

  lcd_cellpix #(.BLINK_TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_pos(scan_pos), .scan_row(scan_row),
    .addr_cnt(addr_cnt), .disp_on(disp_on), .cursor_on(cursor_on),
    .blink_on(blink_on), .shift_ofs(shift_ofs), .dd_we(dd_we),
    .dd_waddr(dd_waddr), .dd_wdata(dd_wdata), .cg_we(cg_we),
    .cg_waddr(cg_waddr), .cg_wdata(cg_wdata), .pix(pix)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  function automatic bit phase_now();
    int c = (edges >= 2) ? edges - 2 : 0;
    return ((c / TICKS) % 2) == 1;
  endfunction

  function automatic int cell_addr(int pos, int sh);
    return ((pos >= 8) ? 64 : 0) + ((pos % 8 + sh) % 40);
  endfunction

  function automatic logic [4:0] model(int pos, int row, int ac, bit d, bit c,
                                       bit b, int sh, bit ph);
    int a = cell_addr(pos, sh);
    logic [7:0] code = dd_m[a];
    logic [4:0] g;
    bit hit = (a == ac);
    if (code[7:4] == 4'h0) g = cg_m[{code[2:0], 3'(row)}][4:0];
    else                   g = code[4:0] ^ {2'b00, 3'(row)};
    if (!d) return 5'h00;
    if (b && hit && ph) return 5'h1f;
    if (c && hit && row == 7) return 5'h1f;
    return g;
  endfunction

  task automatic chk(string tag, logic [4:0] got, logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: pix=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic dd_wr(int a, logic [7:0] v);
    @(negedge clk);
    dd_we = 1'b1; dd_waddr = 7'(a); dd_wdata = v;
    if ((a % 64) < 40) dd_m[a] = v;
    @(negedge clk);
    dd_we = 1'b0;
  endtask

  task automatic cg_wr(int a, logic [7:0] v);
    @(negedge clk);
    cg_we = 1'b1; cg_waddr = 6'(a); cg_wdata = v; cg_m[a] = v;
    @(negedge clk);
    cg_we = 1'b0;
  endtask

  task automatic step(string tag, int pos, int row, int ac, bit d, bit c,
                      bit b, int sh);
    logic [4:0] e;
    @(negedge clk);
    scan_pos = 4'(pos); scan_row = 3'(row); addr_cnt = 7'(ac);
    disp_on = d; cursor_on = c; blink_on = b; shift_ofs = 6'(sh);
    e = model(pos, row, ac, d, c, b, sh, phase_now());
    @(posedge clk);
    #1 chk(tag, pix, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; scan_pos = '0; scan_row = '0; addr_cnt = '0;
    disp_on = 1'b0; cursor_on = 1'b0; blink_on = 1'b0; shift_ofs = '0;
    dd_we = 1'b0; cg_we = 1'b0; dd_waddr = '0; cg_waddr = '0;
    dd_wdata = '0; cg_wdata = '0;
    repeat (4) @(posedge clk);
    #1 chk("R9 reset dark", pix, 5'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 128; i++) if ((i % 64) < 40) dd_wr(i, 8'($urandom));
    for (int i = 0; i < 64; i++) cg_wr(i, 8'($urandom));

    // R1: split map with zero offset
    dd_wr(8'h00, 8'h5a); dd_wr(8'h07, 8'h33); dd_wr(8'h40, 8'h81); dd_wr(8'h47, 8'hc6);
    for (int r = 0; r < 8; r++) begin
      step("R1 cell0", 0, r, 127, 1, 0, 0, 0);
      step("R1 cell7", 7, r, 127, 1, 0, 0, 0);
      step("R1 cell8", 8, r, 127, 1, 0, 0, 0);
      step("R1 cell15", 15, r, 127, 1, 0, 0, 0);
    end
    // R2: offset window wrap, out-of-window write dropped
    dd_wr(8'h05, 8'h71); dd_wr(8'h66, 8'h9c);
    step("R2 shift", 2, 3, 127, 1, 0, 0, 3);
    step("R2 wrap", 15, 1, 127, 1, 0, 0, 35);
    dd_wr(40, 8'hff); dd_wr(8'h68, 8'hff);
    step("R2 drop lo", 0, 0, 127, 1, 0, 0, 0);
    step("R2 drop hi", 8, 0, 127, 1, 0, 0, 0);
    // R3/R4: codes 00h and 08h same glyph, upper bits masked
    dd_wr(8'h00, 8'h00); dd_wr(8'h01, 8'h08);
    for (int r = 0; r < 8; r++) cg_wr(r, 8'(8'he0 | (r * 3 + 1)));
    for (int r = 0; r < 8; r++) begin
      step("R3 code00", 0, r, 127, 1, 0, 0, 0);
      step("R3 code08", 1, r, 127, 1, 0, 0, 0);
      #1 chk("R4 mask", pix, 5'((r * 3 + 1) & 31));
    end
    // R5: font stub
    dd_wr(8'h02, 8'h4b);
    step("R5 stub", 2, 6, 127, 1, 0, 0, 0);
    #1 chk("R5 stub value", pix, 5'h0b ^ 5'h06);
    // R6: cursor on row 7 only under the counter
    step("R6 cursor row7", 3, 7, 3, 1, 1, 0, 0);
    step("R6 other row", 3, 2, 3, 1, 1, 0, 0);
    step("R6 other cell", 4, 7, 3, 1, 1, 0, 0);
    // R8: dark then restore
    step("R8 off", 0, 4, 0, 0, 1, 1, 0);
    step("R8 restore", 0, 4, 127, 1, 0, 0, 0);
    // R7: blink toggles over several periods
    for (int k = 0; k < 4 * TICKS; k++)
      step("R7 blink", 9, k % 8, 8'h41, 1, 0, 1, 0);
    step("R7 blink other cell", 10, 2, 8'h41, 1, 0, 1, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int p = int'($urandom_range(0, 15));
      int s = int'($urandom_range(0, 39));
      int ac = ($urandom_range(0, 2) != 0) ? cell_addr(p, s) : int'($urandom_range(0, 127));
      if ($urandom_range(0, 19) == 0) dd_wr(int'($urandom_range(0, 127)), 8'($urandom));
      if ($urandom_range(0, 19) == 0) cg_wr(int'($urandom_range(0, 63)), 8'($urandom));
      step("R9 random", p, int'($urandom_range(0, 7)), ac,
           ($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom), s);
    end
    finish_run();
  end
endmodule